// File: doc/BRIEF.md
# Encoder Line Trigger with Jitter Filter

This block turns a two-phase quadrature encoder into a signed position count. It emits a one-clock line pulse each time the count reaches a new line inside a programmable window, bounded by an inclusive lower and upper limit. The pulse fires only on steps taken in the configured acquisition direction: forward means the count goes up, reverse means it goes down.

A mechanical encoder that dithers around one line would fire the same line many times. An optional filter prevents this. It keeps a record of the window lines already acquired and suppresses any line found in it. The record can be emptied in two ways. A manual clear is a command bit written by the host, and it works in any mode. An automatic clear happens while the count sits past the far edge of the window. In forward acquisition that edge is above the upper limit; in reverse acquisition it is below the lower limit. The record holds a generation tag per line, so a clear takes one cycle.

A small state machine follows where the count lies relative to the window. It has three states: `ST_BELOW` (count < lower), `ST_INSIDE` (lower ≤ count ≤ upper) and `ST_ABOVE` (count > upper). There are four named transitions. Enter-low is `ST_BELOW`→`ST_INSIDE`. Exit-high is `ST_INSIDE`→`ST_ABOVE`. Return-high is `ST_ABOVE`→`ST_INSIDE`. Exit-low is `ST_INSIDE`→`ST_BELOW`. A direct `ST_BELOW`↔`ST_ABOVE` transition, the jump, occurs only when the limits are rewritten. Pulses come only from `ST_INSIDE`. The automatic clear is asserted from the state that lies past the far edge.

Top module: `enc_line_trig`

## Requirements
- R1: After reset, the position is 0, there is no pulse, both limits are 0, the mode is manual, the direction is forward, the filter is off and the line record is empty.
- R2: The encoder inputs are synchronised through two flip-flops and decoded 4x. With {A,B} moving 00→10→11→01→00, each transition raises the position by exactly 1. The opposite order lowers it by exactly 1.
- R3: A transition in which A and B both change at once leaves the position unchanged.
- R4: `line_pulse` is exactly one clock wide. It appears only for a position within [lower, upper] inclusive, with the limits compared as signed numbers.
- R5: With the filter off, every step inside the window in the acquisition direction produces one pulse. A step against the acquisition direction never produces a pulse.
- R6: With the filter on, a line already in the record produces no pulse. A line that does fire is added to the record.
- R7: Writing word 0 with bit 26 set empties the record in every mode, including automatic. Lines passed over after that fire again.
- R8: In automatic mode with forward direction, the record is emptied while the position is above the upper limit. Going below the lower limit does not empty it.
- R9: In automatic mode with reverse direction, the record is emptied while the position is below the lower limit. Going above the upper limit does not empty it.
- R10: Mode values 2 and 3 behave exactly like manual mode (0), with no automatic clear. Mode 1 is automatic.
- R11: Register writes use `cfg_wr_en` with `cfg_addr`. Word 0 holds the upper limit in [23:0], the mode in [25:24], the write-only clear command in [26], the direction in [27] (0 = forward, 1 = reverse) and the filter enable in [28]. Word 1 holds the lower limit in [23:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enc_a | input | 1 | Encoder phase A (asynchronous) |
| enc_b | input | 1 | Encoder phase B (asynchronous) |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_addr | input | 1 | Register word select (0 or 1) |
| cfg_wdata | input | 29 | Register write data |
| position | output | POS_W (24) | Signed encoder position |
| line_pulse | output | 1 | One-clock line acquire pulse |

## Verification
Some properties are checked on every cycle. The position moves by at most one per cycle. A simultaneous change of both phases never moves it. A pulse only follows a cycle in the `ST_INSIDE` state. A clear leaves no line reported as acquired. Outside mode 1, only a host command clears the record.

The bench sweeps the position back and forth across the window, including jitter and a negative window, under every combination of filter, direction and mode. Only these sweeps can show the exact number of pulses per pass, the suppression of repeated lines, and which window edge triggers the automatic clear.

// File: rtl/enc_trig_pkg.sv
package enc_trig_pkg;
    typedef enum logic [1:0] {
        ST_BELOW  = 2'd0,
        ST_INSIDE = 2'd1,
        ST_ABOVE  = 2'd2
    } region_e;

    localparam int CFG_W        = 29;
    localparam int F_LIMIT_W    = 24;
    localparam int F_MODE_LSB   = 24;
    localparam int F_CLR_BIT    = 26;
    localparam int F_REV_BIT    = 27;
    localparam int F_FILT_BIT   = 28;
    localparam logic [1:0] MODE_AUTO = 2'd1;
endpackage

// File: rtl/enc_quad_dec.sv
module enc_quad_dec #(
    parameter int POS_W = 24
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    enc_a,
    input  logic                    enc_b,
    output logic signed [POS_W-1:0] pos_q,
    output logic                    step_v,
    output logic                    step_up
);
    logic [1:0] a_sync, b_sync;
    logic [1:0] ab_now, ab_prev;
    logic       go_up, go_dn;

    function automatic logic [1:0] gray_next(input logic [1:0] v);
        case (v)
            2'b00:   return 2'b10;
            2'b10:   return 2'b11;
            2'b11:   return 2'b01;
            default: return 2'b00;
        endcase
    endfunction

    assign ab_now = {a_sync[1], b_sync[1]};
    assign go_up  = (ab_now == gray_next(ab_prev));
    assign go_dn  = (ab_prev == gray_next(ab_now));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_sync  <= '0;
            b_sync  <= '0;
            ab_prev <= '0;
            pos_q   <= '0;
            step_v  <= 1'b0;
            step_up <= 1'b0;
        end else begin
            a_sync  <= {a_sync[0], enc_a};
            b_sync  <= {b_sync[0], enc_b};
            ab_prev <= ab_now;
            step_v  <= go_up | go_dn;
            step_up <= go_up;
            if (go_up)
                pos_q <= pos_q + POS_W'(1);
            else if (go_dn)
                pos_q <= pos_q - POS_W'(1);
        end
    end

    AST_STEP_UNIT: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pos_q) |-> ((pos_q - $past(pos_q)) == POS_W'(1) ||
                             (pos_q - $past(pos_q)) == {POS_W{1'b1}}))
        else $error("position moved by more than one"); // R2

    AST_INVALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ((ab_now[1] != ab_prev[1]) && (ab_now[0] != ab_prev[0])) |=> $stable(pos_q))
        else $error("double-phase change moved position"); // R3
endmodule

// File: rtl/enc_line_rec.sv
module enc_line_rec #(
    parameter int LINES = 1024,
    parameter int GEN_W = 3,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             mark,
    input  logic [IDX_W-1:0] idx,
    output logic             hit
);
    localparam logic [GEN_W-1:0] GEN_FIRST = GEN_W'(1);
    localparam logic [GEN_W-1:0] GEN_LAST  = '1;

    logic [GEN_W-1:0] tags [LINES];
    logic [GEN_W-1:0] gen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gen_q <= GEN_FIRST;
            for (int i = 0; i < LINES; i++) tags[i] <= '0;
        end else if (clr) begin
            if (gen_q == GEN_LAST) begin
                gen_q <= GEN_FIRST;
                for (int i = 0; i < LINES; i++) tags[i] <= '0;
            end else begin
                gen_q <= gen_q + GEN_W'(1);
            end
        end else if (mark) begin
            tags[idx] <= gen_q;
        end
    end

    assign hit = (tags[idx] == gen_q);

    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !hit)
        else $error("line still recorded after clear"); // R7
endmodule

// File: rtl/enc_trig_cfg.sv
module enc_trig_cfg
    import enc_trig_pkg::*;
#(
    parameter int POS_W = 24
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic                    addr,
    input  logic [CFG_W-1:0]        wdata,
    output logic signed [POS_W-1:0] upper_q,
    output logic signed [POS_W-1:0] lower_q,
    output logic [1:0]              mode_q,
    output logic                    rev_q,
    output logic                    filt_q,
    output logic                    clr_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            upper_q <= '0;
            lower_q <= '0;
            mode_q  <= '0;
            rev_q   <= 1'b0;
            filt_q  <= 1'b0;
            clr_q   <= 1'b0;
        end else begin
            clr_q <= 1'b0;
            if (wr_en && !addr) begin
                upper_q <= $signed(wdata[POS_W-1:0]);
                mode_q  <= wdata[F_MODE_LSB +: 2];
                rev_q   <= wdata[F_REV_BIT];
                filt_q  <= wdata[F_FILT_BIT];
                clr_q   <= wdata[F_CLR_BIT];
            end else if (wr_en && addr) begin
                lower_q <= $signed(wdata[POS_W-1:0]);
            end
        end
    end
endmodule

// File: rtl/enc_line_trig.sv
module enc_line_trig
    import enc_trig_pkg::*;
#(
    parameter int POS_W = 24,
    parameter int LINES = 1024,
    parameter int GEN_W = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    enc_a,
    input  logic                    enc_b,
    input  logic                    cfg_wr_en,
    input  logic                    cfg_addr,
    input  logic [CFG_W-1:0]        cfg_wdata,
    output logic signed [POS_W-1:0] position,
    output logic                    line_pulse
);
    localparam int IDX_W = $clog2(LINES);

    logic signed [POS_W-1:0] upper_q, lower_q;
    logic [1:0]              mode_q;
    logic                    rev_q, filt_q, man_clr;
    logic                    step_v, step_up, step_d, step_up_d;
    logic                    rec_hit, rec_clr, fire, in_window, past_edge;
    logic [IDX_W-1:0]        rec_idx;
    region_e                 state_q, state_d;

    enc_trig_cfg #(.POS_W(POS_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .addr(cfg_addr),
        .wdata(cfg_wdata), .upper_q(upper_q), .lower_q(lower_q),
        .mode_q(mode_q), .rev_q(rev_q), .filt_q(filt_q), .clr_q(man_clr)
    );

    enc_quad_dec #(.POS_W(POS_W)) u_dec (
        .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b),
        .pos_q(position), .step_v(step_v), .step_up(step_up)
    );

    enc_line_rec #(.LINES(LINES), .GEN_W(GEN_W)) u_rec (
        .clk(clk), .rst_n(rst_n), .clr(rec_clr), .mark(fire),
        .idx(rec_idx), .hit(rec_hit)
    );

    // Next state: region of the current position against the window.
    always_comb begin
        if (position < lower_q)
            state_d = ST_BELOW;
        else if (position > upper_q)
            state_d = ST_ABOVE;
        else
            state_d = ST_INSIDE;
    end

    // State register; the step is delayed to line up with the state.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_INSIDE;
            step_d    <= 1'b0;
            step_up_d <= 1'b0;
        end else begin
            state_q   <= state_d;
            step_d    <= step_v;
            step_up_d <= step_up;
        end
    end

    // Output decode per state.
    always_comb begin
        in_window = 1'b0;
        past_edge = 1'b0;
        unique case (state_q)
            ST_BELOW:  past_edge = rev_q;
            ST_INSIDE: in_window = 1'b1;
            ST_ABOVE:  past_edge = !rev_q;
            default:   ;
        endcase
    end

    assign rec_idx = IDX_W'(position - lower_q);
    assign fire    = step_d && in_window && (step_up_d != rev_q) && !(filt_q && rec_hit);
    assign rec_clr = man_clr || ((mode_q == MODE_AUTO) && past_edge);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) line_pulse <= 1'b0;
        else        line_pulse <= fire;
    end

    AST_PULSE_INSIDE: assert property (@(posedge clk) disable iff (!rst_n)
        line_pulse |-> $past(state_q == ST_INSIDE))
        else $error("pulse outside the window"); // R4

    AST_RESERVED_NO_AUTO: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_q != MODE_AUTO) && !man_clr) |-> !rec_clr)
        else $error("automatic clear outside automatic mode"); // R10
endmodule

// File: tb/enc_line_trig_bench.sv
`timescale 1ns/1ps
module enc_line_trig_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  enc_ab = 2'b00;
    logic        cfg_wr_en = 1'b0;
    logic        cfg_addr = 1'b0;
    logic [28:0] cfg_wdata = '0;
    logic signed [23:0] position;
    logic        line_pulse;

    int tests = 0, fails = 0, pulse_cnt = 0, exp_pulses = 0, exp_pos = 0;
    int lo_m = 0, hi_m = 0, mode_m = 0;
    bit rev_m = 0, filt_m = 0, done = 0;
    bit rec_m [0:255];

    always #2.5 clk = ~clk;

    enc_line_trig u_enc_line_trig (
        .clk(clk), .rst_n(rst_n), .enc_a(enc_ab[1]), .enc_b(enc_ab[0]),
        .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .position(position), .line_pulse(line_pulse)
    );

    always @(negedge clk) if (rst_n && line_pulse) pulse_cnt++;

    task automatic chk(string req, int actual, int expected);
        tests++;
        if (actual != expected) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
        end
    endtask

    task automatic clear_model();
        for (int i = 0; i < 256; i++) rec_m[i] = 1'b0;
    endtask

    task automatic auto_rule();
        if (mode_m == 1 && ((!rev_m && exp_pos > hi_m) || (rev_m && exp_pos < lo_m)))
            clear_model();
    endtask

    task automatic wr(bit a, logic [28:0] d);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr_en = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    // Word 0: [23:0] upper, [25:24] mode, [26] clear, [27] reverse, [28] filter (R11)
    task automatic set_ctrl(int hi, int mode, bit clr, bit rev, bit filt);
        hi_m = hi; mode_m = mode; rev_m = rev; filt_m = filt;
        if (clr) clear_model();
        auto_rule();
        wr(1'b0, {filt, rev, clr, 2'(mode), 24'(hi)});
    endtask

    task automatic set_lower(int lo);
        lo_m = lo;
        auto_rule();
        wr(1'b1, {5'd0, 24'(lo)});
    endtask

    task automatic step(bit up);
        @(negedge clk);
        if (up) begin
            case (enc_ab)
                2'b00: enc_ab = 2'b10;
                2'b10: enc_ab = 2'b11;
                2'b11: enc_ab = 2'b01;
                default: enc_ab = 2'b00;
            endcase
            exp_pos++;
        end else begin
            case (enc_ab)
                2'b00: enc_ab = 2'b01;
                2'b01: enc_ab = 2'b11;
                2'b11: enc_ab = 2'b10;
                default: enc_ab = 2'b00;
            endcase
            exp_pos--;
        end
        if (exp_pos >= lo_m && exp_pos <= hi_m && (up != rev_m) &&
            !(filt_m && rec_m[exp_pos + 128])) begin
            exp_pulses++;
            rec_m[exp_pos + 128] = 1'b1;
        end
        auto_rule();
        repeat (7) @(negedge clk);
    endtask

    task automatic move_to(int tgt);
        while (exp_pos != tgt) step(tgt > exp_pos);
    endtask

    task automatic chk_state(string req);
        chk({req, " pulses"}, pulse_cnt, exp_pulses);
        chk({req, " position"}, int'(position), exp_pos);
    endtask

    initial begin
        clear_model();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 reset position", int'(position), 0);
        chk("R1 reset pulse", int'(line_pulse), 0);

        // R1: record empty and filter on after reset config
        set_lower(2);
        set_ctrl(9, 0, 0, 0, 1);
        move_to(12);  chk_state("R1 R2 R6 first forward pass");
        move_to(0);   chk_state("R5 reverse steps against forward direction");
        move_to(12);  chk_state("R6 repeat pass suppressed");

        // R7 manual clear, then jitter
        set_ctrl(9, 0, 1, 0, 1);
        move_to(0);   chk_state("R7 after clear, backwards");
        move_to(5);   chk_state("R7 lines fire again");
        for (int k = 0; k < 4; k++) begin step(0); step(1); end
        chk_state("R6 jitter suppressed");
        move_to(12);  chk_state("R6 rest of window");

        // R5 filter off
        set_ctrl(9, 0, 0, 0, 0);
        move_to(0); move_to(12); chk_state("R5 filter off full pass");
        move_to(6);
        for (int k = 0; k < 3; k++) begin step(1); step(0); end
        chk_state("R5 filter off jitter fires every forward step");

        // R3 invalid transition
        @(negedge clk); enc_ab = ~enc_ab; repeat (7) @(negedge clk);
        chk("R3 double change ignored", int'(position), exp_pos);
        @(negedge clk); enc_ab = ~enc_ab; repeat (7) @(negedge clk);
        chk_state("R3 double change back ignored");

        // R8 automatic forward
        set_ctrl(9, 1, 1, 0, 1);
        move_to(0); move_to(12); move_to(0); move_to(12);
        chk_state("R8 auto clear above upper");
        move_to(0); move_to(7); move_to(0);
        chk_state("R8 partial pass");
        move_to(12);  chk_state("R8 below lower keeps record");
        move_to(0); move_to(7);
        set_ctrl(9, 1, 1, 0, 1);
        move_to(0); move_to(9); chk_state("R7 manual clear in auto mode");

        // R9 automatic reverse
        set_ctrl(9, 1, 1, 1, 1);
        move_to(12); move_to(0); move_to(12); move_to(0);
        chk_state("R9 auto clear below lower");
        move_to(12); move_to(5); move_to(12);
        chk_state("R9 above upper keeps record");
        move_to(0);   chk_state("R9 remaining lines");

        // R10 reserved modes behave as manual
        for (int m = 2; m < 4; m++) begin
            set_ctrl(9, m, 1, 0, 1);
            move_to(12); move_to(0); move_to(12); move_to(0);
            chk_state(m == 2 ? "R10 mode 2 no auto clear" : "R10 mode 3 no auto clear");
        end

        // R4 signed window, reverse with filter off
        set_lower(-3);
        set_ctrl(3, 0, 1, 0, 0);
        move_to(-6); move_to(6); chk_state("R4 signed window forward");
        set_ctrl(3, 0, 1, 1, 0);
        move_to(-6); chk_state("R4 R5 signed window reverse");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule